// File: doc/BRIEF.md
# Bidirectional Port with Input-Change Interrupt

This block is an eight-pin general-purpose I/O port addressed over a small register bus with one-cycle read and write strobes. Software writes an output data latch and a direction register. It reads the synchronised pin levels back through the port register. Each pin is modelled as three separate signals: input level, output level and output enable. A per-pin weak pull-up enable is produced from a global pull-up-disable bit and the pin's effective direction. An enabled on-chip peripheral can force any pin's direction without changing the stored direction register.

The upper pins (bits 7:4) also watch for input changes. On every read or write of the port register, the block stores the synchronised levels of those pins as a reference. Each upper pin that is configured as an input is compared with its stored reference every cycle. If any of them differs, a sticky change flag is set. The flag drives both an interrupt request and a wake request. Because the flag is set again on every cycle that a difference remains, an interrupt handler must first access the port register to refresh the reference, and then clear the flag.

Top module: `gpio_chg_port`

## Requirements
- R1: Register addresses are 0 port, 1 direction, 2 option, 3 interrupt control. After reset the direction register reads 0xFF, the data latch is 0, all output enables are 0, option bit 7 (pull-up disable) reads 1 so option reads 0x80, and the change flag is 0.
- R2: pin_o carries the data latch. pin_oe_o[i] is 1 exactly when pin i's effective direction is output. A direction bit value of 1 means input and 0 means output.
- R3: A read of address 0 returns pin_i through a two-flop synchroniser. A level driven before a rising edge appears in the read data after the second rising edge.
- R4: Changes on pins 3:0 never set the change flag.
- R5: A pin in bits 7:4 whose effective direction is output is excluded from the change comparison.
- R6: The flag, at bit 0 of address 3, is set on the third rising edge after an input pin in 7:4 starts to differ from its reference. It stays set after the pin returns to its reference level.
- R7: While a difference persists, writing 0 to bit 0 of address 3 leaves the flag set.
- R8: Any read or write of address 0 reloads the reference from the synchronised pins. After that, writing 0 to the flag bit clears it.
- R9: chg_irq_o and wake_o both follow the change flag.
- R10: pull_en_o[i] is 1 exactly when option bit 7 is 0 and pin i's effective direction is input.
- R11: When periph_ovr_en_i[i] is 1, the effective direction of pin i is periph_ovr_dir_i[i] (1 input, 0 output). The direction register read-back is unchanged.
- R12: When a set condition and a software clear fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (reference reload on port read) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Pin output levels |
| pin_oe_o | output | 8 | Pin output enables |
| pull_en_o | output | 8 | Weak pull-up enables |
| periph_ovr_en_i | input | 8 | Per-pin peripheral direction override enable |
| periph_ovr_dir_i | input | 8 | Forced direction while overridden, 1 input |
| chg_irq_o | output | 1 | Change interrupt request |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
The bench times the flag against the synchroniser depth. A design that compared raw pins, or that used the previous cycle instead of the reference, would raise the flag one edge early, or would drop it once the pin settled. It tries to clear the flag while a difference remains, and also on the very edge the difference first appears. A design that gave priority to the clear would lose the event. It toggles the low pins and toggles an upper pin that is driving an output, and expects no flag: a design that compared all eight pins or ignored direction would fire there. It applies peripheral overrides and pull-up combinations and checks that the direction read-back is untouched. A design that wrote the override into the register, or derived pull-ups from the stored bit, would fail those checks.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_OPT  = 2'd2,
    REG_INTC = 2'd3
  } reg_sel_e;

  localparam int INTC_FLAG_BIT = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_dir_ctl.sv
module gpio_dir_ctl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] tris_i,
  input  logic [WIDTH-1:0] ovr_en_i,
  input  logic [WIDTH-1:0] ovr_dir_i,
  input  logic             pu_dis_i,
  output logic [WIDTH-1:0] eff_dir_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] pull_en_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    // peripheral override wins; stored register untouched
    assign eff_dir_o[i] = ovr_en_i[i] ? ovr_dir_i[i] : tris_i[i];
    assign oe_o[i]      = ~eff_dir_o[i];
    assign pull_en_o[i] = ~pu_dis_i & eff_dir_o[i];
  end
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int WIDTH   = 8,
  parameter int CHG_LSB = 4,
  localparam int CHG_W  = WIDTH - CHG_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_sync_i,
  input  logic [WIDTH-1:0] eff_dir_i,
  input  logic             refresh_i,
  input  logic             flag_wr_i,
  input  logic             flag_wval_i,
  output logic [CHG_W-1:0] snap_o,
  output logic             mismatch_o,
  output logic             flag_o
);
  logic [CHG_W-1:0] snap_q;
  logic [CHG_W-1:0] diff;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (refresh_i) snap_q <= pin_sync_i[WIDTH-1:CHG_LSB];
  end

  // outputs excluded: direction 1 = input
  assign diff       = (pin_sync_i[WIDTH-1:CHG_LSB] ^ snap_q) & eff_dir_i[WIDTH-1:CHG_LSB];
  assign mismatch_o = |diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (mismatch_o) flag_q <= 1'b1;  // set beats software write
    else if (flag_wr_i)  flag_q <= flag_wval_i;
  end

  assign snap_o = snap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int CHG_LSB     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [WIDTH-1:0]  bus_wdata_i,
  output logic [WIDTH-1:0]  bus_rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic [WIDTH-1:0]  pull_en_o,
  input  logic [WIDTH-1:0]  periph_ovr_en_i,
  input  logic [WIDTH-1:0]  periph_ovr_dir_i,
  output logic              chg_irq_o,
  output logic              wake_o
);
  localparam int CHG_W      = WIDTH - CHG_LSB;
  localparam int PU_DIS_BIT = WIDTH - 1;

  logic [WIDTH-1:0] data_q, tris_q, pin_sync, eff_dir;
  logic             pu_dis_q;
  logic [CHG_W-1:0] snap;
  logic             mismatch, flag;
  logic             sel_port, sel_dir, sel_opt, sel_intc;
  logic             port_acc, intc_wr;

  assign sel_port = reg_sel_e'(bus_addr_i) == REG_PORT;
  assign sel_dir  = reg_sel_e'(bus_addr_i) == REG_DIR;
  assign sel_opt  = reg_sel_e'(bus_addr_i) == REG_OPT;
  assign sel_intc = reg_sel_e'(bus_addr_i) == REG_INTC;
  assign port_acc = sel_port & (bus_rd_i | bus_wr_i);
  assign intc_wr  = sel_intc & bus_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      tris_q   <= '1;
      pu_dis_q <= 1'b1;
    end else if (bus_wr_i) begin
      if (sel_port) data_q   <= bus_wdata_i;
      if (sel_dir)  tris_q   <= bus_wdata_i;
      if (sel_opt)  pu_dis_q <= bus_wdata_i[PU_DIS_BIT];
    end
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_dir_ctl #(.WIDTH(WIDTH)) u_dir (
    .tris_i   (tris_q),
    .ovr_en_i (periph_ovr_en_i),
    .ovr_dir_i(periph_ovr_dir_i),
    .pu_dis_i (pu_dis_q),
    .eff_dir_o(eff_dir),
    .oe_o     (pin_oe_o),
    .pull_en_o(pull_en_o)
  );

  gpio_chg_det #(.WIDTH(WIDTH), .CHG_LSB(CHG_LSB)) u_chg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_sync_i (pin_sync),
    .eff_dir_i  (eff_dir),
    .refresh_i  (port_acc),
    .flag_wr_i  (intc_wr),
    .flag_wval_i(bus_wdata_i[INTC_FLAG_BIT]),
    .snap_o     (snap),
    .mismatch_o (mismatch),
    .flag_o     (flag)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_sel_e'(bus_addr_i))
      REG_PORT: bus_rdata_o = pin_sync;
      REG_DIR:  bus_rdata_o = tris_q;
      REG_OPT:  bus_rdata_o[PU_DIS_BIT] = pu_dis_q;
      REG_INTC: bus_rdata_o[INTC_FLAG_BIT] = flag;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign pin_o     = data_q;
  assign chg_irq_o = flag;
  assign wake_o    = flag;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int WIDTH   = 8,
  parameter int CHG_LSB = 4,
  localparam int CHG_W  = WIDTH - CHG_LSB
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] pin_sync,
  input logic [WIDTH-1:0] eff_dir,
  input logic [CHG_W-1:0] snap,
  input logic             flag,
  input logic             port_acc,
  input logic             intc_wr,
  input logic             dir_wr,
  input logic [WIDTH-1:0] tris_q,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [WIDTH-1:0] pull_en_o
);
  logic diff_any;
  assign diff_any = |((pin_sync[WIDTH-1:CHG_LSB] ^ snap) & eff_dir[WIDTH-1:CHG_LSB]);

  a_r7_reassert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_any |=> flag);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !intc_wr) |=> flag);

  a_r8_snap_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_acc |=> (snap == $past(pin_sync[WIDTH-1:CHG_LSB])));

  a_r11_dir_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_wr |=> $stable(tris_q));

  a_r10_pull_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & pin_oe_o) == '0);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH), .CHG_LSB(CHG_LSB)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pin_sync (pin_sync),
  .eff_dir  (eff_dir),
  .snap     (snap),
  .flag     (flag),
  .port_acc (port_acc),
  .intc_wr  (intc_wr),
  .dir_wr   (sel_dir & bus_wr_i),
  .tris_q   (tris_q),
  .pin_oe_o (pin_oe_o),
  .pull_en_o(pull_en_o)
);

// File: tb/tb_gpio_chg_port.sv
module tb_gpio_chg_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {dir, opt, ovr_en, ovr_dir, exp_oe, exp_pull}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'h0F, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h0F},
    {8'h0F, 8'h80, 8'h00, 8'h00, 8'hF0, 8'h00},
    {8'hFF, 8'h00, 8'h03, 8'h00, 8'h03, 8'hFC},
    {8'h00, 8'h00, 8'h30, 8'h30, 8'hCF, 8'h30},
    {8'hA5, 8'h80, 8'hF0, 8'h0F, 8'hFA, 8'h00}
  };

  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata, pin = 0, pin_o, oe, pull, ovr_en = 0, ovr_dir = 0;
  logic       irq, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_chg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pin), .pin_o(pin_o),
    .pin_oe_o(oe), .pull_en_o(pull), .periph_ovr_en_i(ovr_en),
    .periph_ovr_dir_i(ovr_dir), .chg_irq_o(irq), .wake_o(wake)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1; #1;
    d = rdata;
    @(posedge clk); @(negedge clk);
    rd = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    addr = a; #1;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    peek(1, r); check("R1 dir", r, 8'hFF);
    peek(2, r); check("R1 opt", r, 8'h80);
    peek(3, r); check("R1 flag", r, 8'h00);
    check("R1 oe", oe, 8'h00);
    check("R1 pin_o", pin_o, 8'h00);
    check("R1 pull", pull, 8'h00);

    bus_write(0, 8'hA5);
    check("R2 pin_o", pin_o, 8'hA5);

    // R2 R10 R11 vector table
    for (int i = 0; i < NVEC; i++) begin
      bus_write(1, VEC[i][47:40]);
      bus_write(2, VEC[i][39:32]);
      ovr_en = VEC[i][31:24]; ovr_dir = VEC[i][23:16];
      #1;
      check("R2 oe", oe, VEC[i][15:8]);
      check("R10 pull", pull, VEC[i][7:0]);
      peek(1, r); check("R11 dir readback", r, VEC[i][47:40]);
    end
    ovr_en = 0; ovr_dir = 0;
    bus_write(1, 8'hFF);
    bus_write(2, 8'h80);

    // R3 synchroniser latency, R4 low pins ignored
    pin = 8'h05;
    step(1); peek(0, r); check("R3 not yet", r, 8'h00);
    step(1); peek(0, r); check("R3 synced", r, 8'h05);
    step(3); check("R4 low pins no flag", {7'b0, irq}, 8'h00);

    // R6 timing and stickiness, R9
    bus_read(0, r);
    pin = 8'h15;
    step(2); check("R6 not early", {7'b0, irq}, 8'h00);
    step(1); check("R6 flag set", {7'b0, irq}, 8'h01);
    check("R9 wake", {7'b0, wake}, 8'h01);
    peek(3, r); check("R6 flag bit0", r, 8'h01);
    pin = 8'h05;
    step(4); check("R6 sticky", {7'b0, irq}, 8'h01);

    // R7 clear while mismatch persists
    pin = 8'h25;
    step(3);
    bus_write(3, 8'h00);
    step(1); check("R7 clear ignored", {7'b0, irq}, 8'h01);

    // R8 read refresh then clear
    bus_read(0, r);
    bus_write(3, 8'h00);
    check("R8 cleared after read", {7'b0, irq}, 8'h00);
    check("R9 wake cleared", {7'b0, wake}, 8'h00);

    // R8 write refresh then clear
    pin = 8'h65;
    step(3); check("R8 flag set", {7'b0, irq}, 8'h01);
    bus_write(0, 8'h00);
    bus_write(3, 8'h00);
    check("R8 cleared after write", {7'b0, irq}, 8'h00);

    // R12 set and clear on same edge
    pin = 8'hE5;
    step(2);
    bus_write(3, 8'h00);
    check("R12 set wins", {7'b0, irq}, 8'h01);

    // R5 output pin excluded
    bus_read(0, r);
    bus_write(3, 8'h00);
    bus_write(1, 8'h7F);
    pin = 8'h65;
    step(4); check("R5 output excluded", {7'b0, irq}, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule